// File: doc/BRIEF.md
# PCI Inbound Address Router

This block sits behind the PCI and AGP target ports of a system controller and decides, for every address presented by an external bus master, where the transaction is allowed to go. A master address can be sent straight to system memory, sent to the graphics aperture path (where a remapping table later turns it into a memory address), or refused so that the target logic can terminate the cycle with a master abort.

The decision uses three inputs that belong to the rest of the chip. The first is the physical top of installed memory, supplied by the memory controller. The second and third are the base and the size of the graphics aperture, supplied by a configuration register. The aperture size is given as a power-of-two exponent, and the base is aligned to that size. Inbound I/O cycles are always refused. Addresses in the legacy video and option-ROM window (0xA0000 to 0xFFFFF) are kept away from memory unless a mode input opens that window.

The request is presented with a one-cycle valid strobe. The route code and the target address appear, registered, on the clock edge after the strobe.

Top module: `pci_inbound_router`

## Requirements
- R1: While reset is asserted and after its release, until the first request, `route_valid` is 0, `route_code` is 0 and `route_addr` is 0.
- R2: `route_valid` is high in exactly the cycle after a cycle in which `req_valid` is high. `route_code` and `route_addr` change only on the edge that captures a request.
- R3: The route code is encoded as 2'b00 = no target, 2'b01 = system memory, 2'b10 = graphics aperture. The value 2'b11 is never produced.
- R4: A non-I/O address below `tom_addr` that is not blocked by the legacy rule routes to system memory, and `route_addr` equals the request address.
- R5: A non-I/O address at or above `tom_addr` with `ap_base <= addr < ap_base + 2**ap_size_log2` routes to the aperture, and `route_addr` equals `addr - ap_base`.
- R6: A request with `req_is_io` set yields no target and `route_addr` 0, whatever its address.
- R7: With `legacy_open` low, any address from 0xA0000 to 0xFFFFF inclusive yields no target, even when it lies below `tom_addr`.
- R8: With `legacy_open` high, addresses in 0xA0000 to 0xFFFFF are decoded like any other address. They go to memory when below `tom_addr`, and to no target when above it and outside the aperture.
- R9: A non-I/O address that matches neither memory nor the aperture yields no target with `route_addr` 0.
- R10: The memory check takes priority over the aperture. An address below `tom_addr` goes to system memory even when it falls inside the aperture window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A master address is presented this cycle |
| req_addr | input | 32 | Master address |
| req_is_io | input | 1 | Request is an I/O cycle |
| tom_addr | input | 32 | Physical top of memory (first address above DRAM) |
| ap_base | input | 32 | Aperture base, aligned to the aperture size |
| ap_size_log2 | input | 5 | Aperture size exponent; size is 2**ap_size_log2 bytes |
| legacy_open | input | 1 | Lets 0xA0000–0xFFFFF reach normal decoding |
| route_valid | output | 1 | Registered route is valid |
| route_code | output | 2 | Registered route (see R3) |
| route_addr | output | 32 | Memory address or aperture offset; 0 when no target |

## Verification
The legacy window is swept in 4 KB steps from below 0xA0000 to past 0x100000, with the window closed and then open. This separates the blocking rule from the top-of-memory rule at both edges of the window. The top of memory and the aperture edges are probed one byte to either side, at every aperture size from 4 KB to 256 MB, which exposes off-by-one and mask-width faults in the range compare and the offset subtraction. Further configurations place the aperture under the top of memory to check priority, place memory below the legacy window, and place the aperture at the very top of the address space to check for carry overflow. I/O requests are also driven at addresses that would otherwise reach memory or the aperture.

// File: rtl/pir_pkg.sv
package pir_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_DRAM = 2'b01,
    ROUTE_APER = 2'b10
  } route_e;

  localparam logic [31:0] LEGACY_LO = 32'h000A_0000;
  localparam logic [31:0] LEGACY_HI = 32'h000F_FFFF;
endpackage

// File: rtl/pir_legacy_window.sv
module pir_legacy_window #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LO = 'h000A_0000,
  parameter logic [ADDR_W-1:0] HI = 'h000F_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  always_comb hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/pir_aperture_match.sv
module pir_aperture_match #(
  parameter int ADDR_W = 32,
  localparam int LOG_W = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LOG_W-1:0]  size_log2,
  output logic              hit,
  output logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] low_mask
);
  // Ones in every bit below the aperture size exponent.
  function automatic logic [ADDR_W-1:0] size_mask(input logic [LOG_W-1:0] k);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  always_comb begin
    low_mask = size_mask(size_log2);
    hit      = ((addr ^ base) & ~low_mask) == '0;
    offset   = addr - base;
  end
endmodule

// File: rtl/pir_route_reg.sv
module pir_route_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  pir_pkg::route_e   in_code,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output pir_pkg::route_e   out_code,
  output logic [ADDR_W-1:0] out_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= pir_pkg::ROUTE_NONE;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code <= in_code;
        out_addr <= in_addr;
      end
    end
  end

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_code != 2'b11);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_code) && $stable(out_addr));
endmodule

// File: rtl/pci_inbound_router.sv
module pci_inbound_router #(
  parameter int ADDR_W = 32,
  localparam int LOG_W = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] tom_addr,
  input  logic [ADDR_W-1:0] ap_base,
  input  logic [LOG_W-1:0]  ap_size_log2,
  input  logic              legacy_open,
  output logic              route_valid,
  output logic [1:0]        route_code,
  output logic [ADDR_W-1:0] route_addr
);
  import pir_pkg::*;

  // Named decode events, visible to the assertions below.
  logic              legacy_hit;
  logic              legacy_block;
  logic              below_tom;
  logic              aper_hit;
  logic [ADDR_W-1:0] aper_off;
  logic [ADDR_W-1:0] aper_mask;
  route_e            next_code;
  logic [ADDR_W-1:0] next_addr;
  route_e            code_q;

  pir_legacy_window #(
    .ADDR_W(ADDR_W),
    .LO    (ADDR_W'(LEGACY_LO)),
    .HI    (ADDR_W'(LEGACY_HI))
  ) u_legacy (
    .addr(req_addr),
    .hit (legacy_hit)
  );

  pir_aperture_match #(.ADDR_W(ADDR_W)) u_aper (
    .addr     (req_addr),
    .base     (ap_base),
    .size_log2(ap_size_log2),
    .hit      (aper_hit),
    .offset   (aper_off),
    .low_mask (aper_mask)
  );

  // Priority: I/O refusal, legacy block, memory, aperture, nothing.
  always_comb begin
    legacy_block = legacy_hit && !legacy_open;
    below_tom    = req_addr < tom_addr;
    next_code    = ROUTE_NONE;
    next_addr    = '0;
    if (req_is_io || legacy_block) begin
      next_code = ROUTE_NONE;
    end else if (below_tom) begin
      next_code = ROUTE_DRAM;
      next_addr = req_addr;
    end else if (aper_hit) begin
      next_code = ROUTE_APER;
      next_addr = aper_off;
    end
  end

  pir_route_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_code  (next_code),
    .in_addr  (next_addr),
    .out_valid(route_valid),
    .out_code (code_q),
    .out_addr (route_addr)
  );

  assign route_code = code_q;

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> route_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !route_valid);
  assert_dram_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_is_io && !legacy_block && below_tom
    |=> route_code == ROUTE_DRAM && route_addr == $past(req_addr));
  assert_offset_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && aper_hit |-> (aper_off & ~aper_mask) == '0);
  assert_io_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_is_io |=> route_code == ROUTE_NONE && route_addr == '0);
  assert_legacy_kept_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && legacy_hit && !legacy_open |=> route_code == ROUTE_NONE);
  assert_memory_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_is_io && below_tom && aper_hit && !legacy_block
    |=> route_code == ROUTE_DRAM);
endmodule

// File: tb/tb_pci_inbound_router.sv
`timescale 1ns/1ps
module tb_pci_inbound_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_is_io;
  logic [31:0] tom_addr;
  logic [31:0] ap_base;
  logic [4:0]  ap_size_log2;
  logic        legacy_open;
  logic        route_valid;
  logic [1:0]  route_code;
  logic [31:0] route_addr;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #5 clk = ~clk;

  pci_inbound_router dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .tom_addr(tom_addr), .ap_base(ap_base),
    .ap_size_log2(ap_size_log2), .legacy_open(legacy_open),
    .route_valid(route_valid), .route_code(route_code), .route_addr(route_addr)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Expected route from wide arithmetic on the window edges.
  task automatic model(input logic [31:0] a, input logic io,
                       output logic [1:0] code, output logic [31:0] ad,
                       output string req);
    logic [63:0] lo = {32'b0, ap_base};
    logic [63:0] hi = lo + (64'd1 << ap_size_log2);
    logic in_leg = (a >= 32'hA0000) && (a < 32'h100000);
    code = 2'b00; ad = 32'h0;
    if (io) req = "R6";
    else if (in_leg && !legacy_open) req = "R7";
    else if (a < tom_addr) begin
      code = 2'b01; ad = a;
      req = in_leg ? "R8" : ({32'b0, a} >= lo && {32'b0, a} < hi) ? "R10" : "R4";
    end else if ({32'b0, a} >= lo && {32'b0, a} < hi) begin
      code = 2'b10; ad = a - ap_base; req = "R5";
    end else req = in_leg ? "R8" : "R9";
  endtask

  task automatic probe(input logic [31:0] a, input logic io);
    logic [1:0] ec; logic [31:0] ea; string rq;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_io = io;
    model(a, io, ec, ea, rq);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 valid", {63'b0, route_valid}, 64'd1);
    check({rq, " code"}, {62'b0, route_code}, {62'b0, ec});
    check({rq, " addr"}, {32'b0, route_addr}, {32'b0, ea});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_is_io = 1'b0;
    tom_addr = 32'h0400_0000; ap_base = 32'h1000_0000; ap_size_log2 = 5'd24;
    legacy_open = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid", {63'b0, route_valid}, 64'd0);
    check("R1 code", {62'b0, route_code}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr", {32'b0, route_addr}, 64'd0);
    check("R1 valid after release", {63'b0, route_valid}, 64'd0);

    // R7 / R8: legacy window sweep, closed then open.
    for (int m = 0; m < 2; m++) begin
      legacy_open = m[0];
      for (logic [31:0] a = 32'h90000; a < 32'h110000; a += 32'h1000) begin
        probe(a, 1'b0);
        probe(a | 32'hFFF, 1'b0);
      end
    end
    legacy_open = 1'b0;

    // R2: idle cycle gives no valid and keeps last code.
    probe(32'h0000_1000, 1'b0);
    @(negedge clk);
    check("R2 idle valid", {63'b0, route_valid}, 64'd0);
    check("R2 idle hold", {62'b0, route_code}, 64'd1);

    // R4 / R9: top of memory edges.
    probe(tom_addr - 1, 1'b0);
    probe(tom_addr, 1'b0);
    probe(tom_addr + 1, 1'b0);

    // R5 / R9: aperture edges at every size.
    for (int k = 12; k <= 28; k++) begin
      logic [31:0] len;
      ap_size_log2 = 5'(k);
      len = 32'd1 << k;
      probe(ap_base - 1, 1'b0);
      probe(ap_base, 1'b0);
      probe(ap_base + len - 1, 1'b0);
      probe(ap_base + len, 1'b0);
      probe(ap_base + (len >> 1) + 3, 1'b0);
    end

    // R6: I/O refused everywhere.
    probe(32'h0000_1000, 1'b1);
    probe(32'h000B_8000, 1'b1);
    probe(ap_base + 32'h40, 1'b1);
    probe(32'h0000_0CF8, 1'b1);

    // R10: aperture below top of memory.
    tom_addr = 32'h2000_0000; ap_size_log2 = 5'd24;
    probe(ap_base, 1'b0);
    probe(ap_base + 32'h12345, 1'b0);

    // R8: memory ends below the legacy window, window open.
    tom_addr = 32'h0008_0000; legacy_open = 1'b1;
    probe(32'h000C_0000, 1'b0);
    probe(32'h0007_FFFF, 1'b0);

    // R5: aperture at the top of the address space.
    ap_base = 32'hF000_0000; ap_size_log2 = 5'd28;
    probe(32'hFFFF_FFFF, 1'b0);
    probe(32'hEFFF_FFFF, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule